// File: doc/BRIEF.md
# Serial LCD command framer

This block turns write requests for a monochrome graphic LCD controller into frames on a three-wire synchronous link made of a chip-select, a serial clock and a data line. A request is either one instruction byte, one display data byte, or a burst of display data bytes pulled one at a time from an upstream byte stream. Each frame opens with a sync byte that carries the register-select flag. Every logical byte then follows as two wire bytes, each of which holds one nibble in its upper half. All bits go out MSB first.

After the last bit of a frame the chip-select drops. The block then waits for a settle time before it pulses done and becomes ready again. The request supplies the settle time in cycles. The block never lets it fall below a floor: a general floor applies to every frame, and a longer one applies to the clear-display instruction. A host sequencer decides what to send. It uses done, or simply the request handshake, to pace the controller.

Top module: `lcd_serial_framer`

## Requirements
- R1: After reset, lcd_cs, lcd_sclk, lcd_sdo, done and strm_ready are low and req_ready is high.
- R2: The first wire byte of an instruction frame is 0xF8. Its bits 7..3 are ones, bit 2 (the write/read flag) is always 0, bit 1 (register select) is 0 and bit 0 is 0.
- R3: Each logical byte goes out as two wire bytes. The first is {byte[7:4], 4'b0000} and the second is {byte[3:0], 4'b0000}.
- R4: Each bit holds lcd_sdo for SCLK_HALF cycles with lcd_sclk low, then for SCLK_HALF cycles with lcd_sclk high. Bits go MSB first, and lcd_sdo never changes while lcd_sclk stays high.
- R5: lcd_cs rises in the cycle after a request is accepted. It stays high through the high phase of the last bit of the frame, and it is low at all other times.
- R6: A burst frame is one sync byte followed by BURST_LEN stream bytes, which makes 1+2*BURST_LEN wire bytes. strm_ready is high only while a high nibble needs a new byte. The link then waits with lcd_cs high, lcd_sclk low and lcd_sdo low until strm_valid arrives.
- R7: After lcd_cs falls, the block spends S+1 cycles with lcd_cs low, where S is the effective settle count. done is then high for exactly one cycle.
- R8: S equals max(req_delay, MIN_WAIT). For an instruction frame with byte 0x01, S equals max(req_delay, CLEAR_WAIT).
- R9: req_ready is high only when no frame is in progress, and that includes the done cycle. A request that is pending during the done cycle is accepted at the end of that cycle.
- R10: req_kind encodes the frame type: 2'b00 is an instruction, 2'b01 is a single data byte, and 2'b1x is a burst. Data and burst frames start with sync byte 0xFA, which has register select (bit 1) set.
- R11: For a burst, req_byte has no effect. The data comes only from the stream, and the clear-display floor does not apply even when req_byte is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | Frame type: 00 instruction, 01 data, 1x burst |
| req_byte | input | 8 | Instruction or data byte for single frames |
| req_delay | input | DELAY_W | Requested settle time in cycles |
| strm_valid | input | 1 | Burst byte offered |
| strm_ready | output | 1 | Burst byte taken when high with strm_valid |
| strm_byte | input | 8 | Burst data byte |
| lcd_cs | output | 1 | Active-high chip select |
| lcd_sclk | output | 1 | Serial clock, idle low |
| lcd_sdo | output | 1 | Serial data, sampled by the display on the rising edge |
| done | output | 1 | One-cycle pulse when the settle time ends |

## Verification
The done pulse of one frame and the acceptance of the next request can happen in the same cycle, because req_ready already returns in the done cycle. The bench provokes this by holding the next request valid while the previous frame is still shifting. The reference queue expects done and req_ready together and then, with no idle cycle between them, lcd_cs high in the following cycle. A second overlap lies between the end of a nibble byte and the fetch of the next stream byte. The bench delays strm_valid by a different number of cycles for each burst byte and checks that the clock stays low for exactly that many extra cycles.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FETCH  = 2'd2,
        ST_SETTLE = 2'd3
    } lcdf_state_e;

    typedef enum logic [1:0] {
        PK_SYNC = 2'd0,
        PK_HI   = 2'd1,
        PK_LO   = 2'd2
    } pack_sel_e;

    localparam logic [1:0] KIND_INSTR = 2'b00;
    localparam logic [7:0] CMD_CLEAR  = 8'h01;

endpackage

// File: rtl/lcdf_nibble_pack.sv
module lcdf_nibble_pack
    import lcdf_pkg::*;
(
    input  pack_sel_e   sel,
    input  logic        rs,
    input  logic [7:0]  src,
    output logic [7:0]  wbyte
);

    always_comb begin
        case (sel)
            PK_SYNC: wbyte = {5'b11111, 1'b0, rs, 1'b0};
            PK_HI:   wbyte = {src[7:4], 4'b0000};
            default: wbyte = {src[3:0], 4'b0000};
        endcase
    end

endmodule

// File: rtl/lcdf_settle_calc.sv
module lcdf_settle_calc
    import lcdf_pkg::*;
#(
    parameter int DELAY_W    = 16,
    parameter int MIN_WAIT   = 18,
    parameter int CLEAR_WAIT = 400
) (
    input  logic [1:0]         kind,
    input  logic [7:0]         cmd,
    input  logic [DELAY_W-1:0] delay,
    output logic [DELAY_W-1:0] eff
);

    localparam logic [DELAY_W-1:0] FLOOR_GEN   = DELAY_W'(MIN_WAIT);
    localparam logic [DELAY_W-1:0] FLOOR_CLEAR = DELAY_W'(CLEAR_WAIT);

    logic [DELAY_W-1:0] floor_v;

    always_comb begin
        floor_v = (kind == KIND_INSTR && cmd == CMD_CLEAR) ? FLOOR_CLEAR : FLOOR_GEN;
        eff     = (delay > floor_v) ? delay : floor_v;
    end

endmodule

// File: rtl/lcdf_sclk_gen.sv
module lcdf_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_evt
);

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(SCLK_HALF - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } gen_t;

    gen_t g_d, g_q;
    logic phase_end;

    always_comb begin
        g_d       = g_q;
        phase_end = run && (g_q.cnt == CNT_LAST);
        if (!run) begin
            g_d.cnt  = '0;
            g_d.sclk = 1'b0;
        end else if (phase_end) begin
            g_d.cnt  = '0;
            g_d.sclk = ~g_q.sclk;
        end else begin
            g_d.cnt  = g_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk     = g_q.sclk;
    assign fall_evt = phase_end && g_q.sclk;

endmodule

// File: rtl/lcd_serial_framer.sv
module lcd_serial_framer
    import lcdf_pkg::*;
#(
    parameter int SCLK_HALF  = 2,
    parameter int BURST_LEN  = 16,
    parameter int DELAY_W    = 16,
    parameter int MIN_WAIT   = 18,
    parameter int CLEAR_WAIT = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [7:0]         req_byte,
    input  logic [DELAY_W-1:0] req_delay,
    input  logic               strm_valid,
    output logic               strm_ready,
    input  logic [7:0]         strm_byte,
    output logic               lcd_cs,
    output logic               lcd_sclk,
    output logic               lcd_sdo,
    output logic               done
);

    localparam int WI_LAST_BURST = 2 * BURST_LEN;
    localparam int WI_W          = $clog2(WI_LAST_BURST + 1);

    typedef struct packed {
        lcdf_state_e        st;
        logic               burst;
        logic               rs;
        logic [7:0]         dbyte;
        logic [7:0]         shreg;
        logic [2:0]         bitn;
        logic [WI_W-1:0]    widx;
        logic [DELAY_W-1:0] wait_cnt;
        logic               cs;
        logic               sdo;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;

    logic               fall_evt;
    logic [DELAY_W-1:0] eff_delay;
    logic [7:0]         sync_byte;
    logic [7:0]         pk_byte;
    logic [7:0]         pk_src;
    pack_sel_e          pk_sel;
    logic [WI_W-1:0]    nxt_idx;
    logic [WI_W-1:0]    last_idx;

    lcdf_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st == ST_SHIFT),
        .sclk     (lcd_sclk),
        .fall_evt (fall_evt)
    );

    lcdf_settle_calc #(
        .DELAY_W    (DELAY_W),
        .MIN_WAIT   (MIN_WAIT),
        .CLEAR_WAIT (CLEAR_WAIT)
    ) u_settle (
        .kind  (req_kind),
        .cmd   (req_byte),
        .delay (req_delay),
        .eff   (eff_delay)
    );

    lcdf_nibble_pack u_sync_pack (
        .sel   (PK_SYNC),
        .rs    (req_kind[1] | req_kind[0]),
        .src   (req_byte),
        .wbyte (sync_byte)
    );

    lcdf_nibble_pack u_data_pack (
        .sel   (pk_sel),
        .rs    (r_q.rs),
        .src   (pk_src),
        .wbyte (pk_byte)
    );

    // Wire byte index: 0 is the sync byte, odd indices carry high nibbles.
    always_comb begin
        nxt_idx  = r_q.widx + WI_W'(1);
        last_idx = r_q.burst ? WI_W'(WI_LAST_BURST) : WI_W'(2);
        pk_src   = (r_q.st == ST_FETCH) ? strm_byte : r_q.dbyte;
        pk_sel   = (r_q.st == ST_FETCH || nxt_idx[0]) ? PK_HI : PK_LO;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st       = ST_SHIFT;
                    r_d.burst    = req_kind[1];
                    r_d.rs       = req_kind[1] | req_kind[0];
                    r_d.dbyte    = req_byte;
                    r_d.shreg    = sync_byte;
                    r_d.bitn     = '0;
                    r_d.widx     = '0;
                    r_d.wait_cnt = eff_delay;
                end
            end
            ST_SHIFT: begin
                if (fall_evt) begin
                    if (r_q.bitn == 3'd7) begin
                        r_d.bitn = '0;
                        if (r_q.widx == last_idx) begin
                            r_d.st = ST_SETTLE;
                        end else if (r_q.burst && nxt_idx[0]) begin
                            r_d.st   = ST_FETCH;
                            r_d.widx = nxt_idx;
                        end else begin
                            r_d.shreg = pk_byte;
                            r_d.widx  = nxt_idx;
                        end
                    end else begin
                        r_d.shreg = {r_q.shreg[6:0], 1'b0};
                        r_d.bitn  = r_q.bitn + 3'd1;
                    end
                end
            end
            ST_FETCH: begin
                if (strm_valid) begin
                    r_d.dbyte = strm_byte;
                    r_d.shreg = pk_byte;
                    r_d.st    = ST_SHIFT;
                end
            end
            default: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - DELAY_W'(1);
                end
            end
        endcase
        r_d.cs  = (r_d.st == ST_SHIFT) || (r_d.st == ST_FETCH);
        r_d.sdo = (r_d.st == ST_SHIFT) ? r_d.shreg[7] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign strm_ready = (r_q.st == ST_FETCH);
    assign lcd_cs     = r_q.cs;
    assign lcd_sdo    = r_q.sdo;
    assign done       = r_q.done;

endmodule

// File: rtl/lcd_serial_framer_chk.sv
module lcd_serial_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic strm_ready,
    input logic lcd_cs,
    input logic lcd_sclk,
    input logic lcd_sdo,
    input logic done
);

    p_idle_no_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!lcd_cs && !lcd_sclk && !strm_ready));

    p_sdo_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_sdo));

    p_sclk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs |-> !lcd_sclk);

    p_fetch_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strm_ready |-> (lcd_cs && !lcd_sclk && !lcd_sdo));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!lcd_cs && $past(!lcd_cs)));

    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

bind lcd_serial_framer lcd_serial_framer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .strm_ready (strm_ready),
    .lcd_cs     (lcd_cs),
    .lcd_sclk   (lcd_sclk),
    .lcd_sdo    (lcd_sdo),
    .done       (done)
);

// File: tb/lcd_serial_framer_tb_top.sv
module lcd_serial_framer_tb_top;

    localparam int HALF = 2;
    localparam int BL   = 16;
    localparam int DW   = 16;
    localparam int MINW = 18;
    localparam int CLRW = 400;
    // tuple bits: {req_ready, strm_ready, cs, sclk, sdo, done}
    localparam logic [5:0] T_IDLE = 6'b100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [7:0]    req_byte = '0;
    logic [DW-1:0] req_delay = '0;
    logic          strm_valid = 1'b0;
    logic          strm_ready;
    logic [7:0]    strm_byte = '0;
    logic          lcd_cs, lcd_sclk, lcd_sdo, done;

    int n_chk = 0;
    int n_fail = 0;

    logic [5:0] expq[$];
    int         ex_sync[$];
    int         ex_cnt[$];
    int         ex_eff[$];
    string      ex_tag[$];

    int         gaps[BL];
    logic [7:0] sbytes[BL];
    int         sidx = 0;

    always #2 clk = ~clk;

    lcd_serial_framer #(
        .SCLK_HALF(HALF), .BURST_LEN(BL), .DELAY_W(DW),
        .MIN_WAIT(MINW), .CLEAR_WAIT(CLRW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_byte(req_byte), .req_delay(req_delay),
        .strm_valid(strm_valid), .strm_ready(strm_ready), .strm_byte(strm_byte),
        .lcd_cs(lcd_cs), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input logic [5:0] t);
        for (int i = 0; i < n; i++) expq.push_back(t);
    endtask

    task automatic push_wire(input logic [7:0] w);
        for (int b = 7; b >= 0; b--) begin
            push_n(HALF, {4'b0010, w[b], 1'b0} | 6'b000000);
            push_n(HALF, {4'b0011, w[b], 1'b0});
        end
    endtask

    // Reference: expected outputs for every cycle after the accepting edge.
    task automatic build(input logic [1:0] k, input logic [7:0] b, input int d);
        int fl, eff;
        logic [7:0] sy;
        sy = (k == 2'b00) ? 8'hF8 : 8'hFA;
        push_wire(sy);
        if (k[1]) begin
            for (int j = 0; j < BL; j++) begin
                push_n(1 + gaps[j], 6'b011000);
                push_wire({sbytes[j][7:4], 4'h0});
                push_wire({sbytes[j][3:0], 4'h0});
            end
        end else begin
            push_wire({b[7:4], 4'h0});
            push_wire({b[3:0], 4'h0});
        end
        fl  = (k == 2'b00 && b == 8'h01) ? CLRW : MINW;
        eff = (d > fl) ? d : fl;
        push_n(eff + 1, 6'b000000);
        expq.push_back(6'b100001);
        ex_sync.push_back(int'(sy));
        ex_cnt.push_back(k[1] ? 1 + 2 * BL : 3);
        ex_eff.push_back(eff);
        ex_tag.push_back((k == 2'b00) ? ((b == 8'h01) ? "R8" : "R2") : (k[1] ? "R11" : "R10"));
    endtask

    logic       prev_sclk = 1'b0;
    logic       prev_cs = 1'b0;
    logic [7:0] cur_b = '0;
    int         nbits = 0;
    int         nbytes = 0;
    int         first_b = 0;
    int         settle_cnt = 0;
    bit         in_settle = 0;

    always @(negedge clk) begin
        logic [5:0] got, ex;
        if (rst_n) begin
            got = {req_ready, strm_ready, lcd_cs, lcd_sclk, lcd_sdo, done};
            ex  = (expq.size() > 0) ? expq.pop_front() : T_IDLE;
            chk(got[5] == ex[5], "R9", "req_ready", got[5], ex[5]);
            chk(got[4] == ex[4], "R6", "strm_ready", got[4], ex[4]);
            chk(got[3] == ex[3], "R5", "lcd_cs", got[3], ex[3]);
            chk(got[2] == ex[2], "R4", "lcd_sclk", got[2], ex[2]);
            chk(got[1] == ex[1], "R3", "lcd_sdo", got[1], ex[1]);
            chk(got[0] == ex[0], "R7", "done", got[0], ex[0]);
            // wire byte decoder on rising serial clock
            if (lcd_cs && lcd_sclk && !prev_sclk) begin
                cur_b = {cur_b[6:0], lcd_sdo};
                nbits++;
                if (nbits == 8) begin
                    if (nbytes == 0) first_b = int'(cur_b);
                    nbytes++;
                    nbits = 0;
                end
            end
            if (prev_cs && !lcd_cs) begin
                in_settle  = 1;
                settle_cnt = 1;
            end else if (in_settle && !lcd_cs && !done) begin
                settle_cnt++;
            end
            if (done && ex_sync.size() > 0) begin
                string tg;
                tg = ex_tag.pop_front();
                chk(first_b == ex_sync[0], (tg == "R11" || tg == "R10") ? "R10" : "R2",
                    "sync byte", first_b, ex_sync[0]);
                chk(nbytes == ex_cnt[0], "R6", "wire byte count", nbytes, ex_cnt[0]);
                chk(settle_cnt == ex_eff[0] + 1, tg, "settle cycles", settle_cnt, ex_eff[0] + 1);
                void'(ex_sync.pop_front());
                void'(ex_cnt.pop_front());
                void'(ex_eff.pop_front());
                nbytes    = 0;
                nbits     = 0;
                in_settle = 0;
            end
            prev_sclk = lcd_sclk;
            prev_cs   = lcd_cs;
            if (req_valid && req_ready) build(req_kind, req_byte, int'(req_delay));
        end
    end

    // stream source: waits gaps[i] extra cycles after strm_ready appears
    initial begin
        forever begin
            @(negedge clk);
            if (strm_ready) begin
                repeat (gaps[sidx]) @(negedge clk);
                strm_valid = 1'b1;
                strm_byte  = sbytes[sidx];
                @(posedge clk);
                #1;
                strm_valid = 1'b0;
                sidx = (sidx + 1) % BL;
            end
        end
    end

    task automatic send(input logic [1:0] k, input logic [7:0] b, input int d);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_kind  = k;
        req_byte  = b;
        req_delay = DW'(d);
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (expq.size() != 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int j = 0; j < BL; j++) begin
            gaps[j]   = 0;
            sbytes[j] = 8'(j * 17 + 3);
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(lcd_cs == 1'b0, "R1", "lcd_cs", lcd_cs, 0);
        chk(lcd_sclk == 1'b0, "R1", "lcd_sclk", lcd_sclk, 0);
        chk(lcd_sdo == 1'b0, "R1", "lcd_sdo", lcd_sdo, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(strm_ready == 1'b0, "R1", "strm_ready", strm_ready, 0);
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);

        send(2'b00, 8'h30, 0);      // R2: instruction, general floor
        wait_idle();
        send(2'b00, 8'h01, 5);      // R8: clear floor
        wait_idle();
        send(2'b00, 8'h0C, 50);     // R8: request above floor
        wait_idle();
        send(2'b01, 8'hA5, 0);      // R10: single data
        wait_idle();
        send(2'b10, 8'h01, 0);      // R11: burst ignores req_byte
        wait_idle();
        for (int j = 0; j < BL; j++) begin
            gaps[j]   = j % 4;
            sbytes[j] = 8'(8'hF0 ^ (j * 29));
        end
        send(2'b11, 8'h00, 25);     // R6: stalled stream
        wait_idle();
        // R9: back-to-back, next request accepted in the done cycle
        send(2'b00, 8'h36, 0);
        send(2'b01, 8'h5A, 30);
        send(2'b00, 8'h01, 0);
        wait_idle();
        finish_run();
    end

endmodule